// File: doc/BRIEF.md
# IPv4 Output Port Lookup Stage

This stage sits in the packet pipeline of a multi-port router. Packets arrive as 72-bit words, each a 64-bit data word with an 8-bit control word. A `wr` strobe and a `rdy` signal pace the words in both directions. The stage stores a whole packet and then decides where the packet goes. It writes that choice into the leading module header as a one-hot queue mask and edits the Ethernet and IPv4 headers as the packet streams out.

The destination is chosen in one of three ways. A packet from a CPU queue is sent out of the MAC port it belongs to. A normal packet is checked first: its destination MAC, its TTL and its header checksum must be valid. If they are, the stage does a longest-prefix route lookup and then a next-hop MAC lookup, after which it rewrites both MAC addresses, decrements TTL and patches the checksum. Any packet that fails a check or misses a lookup goes unchanged to the CPU queue that pairs with its input port.

The route table, the ARP table and the per-port MAC addresses are loaded through one table write port. Queue numbers interleave the two kinds of port: MAC port k is queue 2k and CPU queue k is queue 2k+1.

Word layout is as follows, with words counted from 0 and control `0xff` marking word 0:
- Word 0: byte length in [63:48], input queue number in [18:16], output mask in [7:0].
- Word 1: destination MAC in [63:16], source MAC bits 47:32 in [15:0].
- Word 2: source MAC bits 31:0 in [63:32], IPv4 version/IHL/TOS in [15:0].
- Word 3: TTL in [15:8], protocol in [7:0].
- Word 4: header checksum in [63:48], destination IP bits 31:16 in [15:0].
- Word 5: destination IP bits 15:0 in [63:48].

After word 0, the first word with a nonzero control value ends the packet.

Top module: `ipv4_fwd_stage`

## Requirements
- R1: After reset `in_rdy` is 1 and `out_wr` is 0, and all route and ARP entries are invalid.
- R2: The output copy of word 0 carries in [7:0] exactly one set bit, the chosen queue. MAC port k is queue 2k and CPU queue k is queue 2k+1.
- R3: On forwarding, word 1 [63:16] becomes the next-hop MAC. The source MAC (word 1 [15:0] and word 2 [63:32]) becomes the MAC of the output port.
- R4: On forwarding, TTL (word 3 [15:8]) is reduced by one and the checksum (word 4 [63:48]) is updated, so that the ten header halfwords again sum to 0xFFFF in one's-complement. A TTL of 2 leaves as 1.
- R5: A packet with TTL 0 or 1 goes to queue 2k+1 for input queue 2k, with every word unchanged except the mask.
- R6: A packet whose header halfwords do not sum to 0xFFFF goes to queue 2k+1 unchanged.
- R7: A packet whose destination MAC differs from the MAC of its input port goes to queue 2k+1 unchanged.
- R8: A route entry matches when (dst ^ prefix) & mask is zero. The lowest-index valid match wins and gives MAC port p, which is queue 2p. If no entry matches, the packet goes to queue 2k+1.
- R9: The ARP lookup key is the route's next-hop IP, or the destination IP when the next hop is 0. If the ARP lookup misses, the packet goes to queue 2k+1.
- R10: A packet from input queue 2k+1 goes to queue 2k with every other bit unchanged, whatever its MAC, TTL or checksum.
- R11: Output words keep their input order, appear only while `out_rdy` is 1, and none is lost or repeated under backpressure.
- R12: `in_rdy` stays 0 from the end word of a packet until that packet's last word has left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 64 | Inbound data word |
| in_ctrl | input | 8 | Inbound control word |
| in_wr | input | 1 | Inbound word valid |
| in_rdy | output | 1 | Stage can take an inbound word |
| out_data | output | 64 | Outbound data word |
| out_ctrl | output | 8 | Outbound control word |
| out_wr | output | 1 | Outbound word valid |
| out_rdy | input | 1 | Downstream can take a word |
| tbl_wr | input | 1 | Table write strobe |
| tbl_sel | input | 2 | Target table: 0 route, 1 ARP, 2 port MAC |
| tbl_idx | input | 4 | Entry index |
| tbl_valid | input | 1 | Valid bit for route or ARP entry |
| tbl_key | input | 32 | Route prefix or ARP IP |
| tbl_mask | input | 32 | Route prefix mask |
| tbl_val | input | 48 | Next-hop IP in [31:0] (route) or MAC (ARP, port) |
| tbl_port | input | 2 | Route output MAC port |

## Verification
The assertions take three things for granted about the inbound stream:
- Every packet has exactly one module header.
- Every packet has a single end word.
- Every packet fits in the buffer depth.

The end-of-drain and buffer-overflow properties rely on these. The stimulus keeps within them by building packets of six to nine words, each ending in a `0x10` control word. It toggles `out_rdy` from a fixed LFSR, so that drain stalls land at many word positions.

// File: rtl/ipv4_fwd_pkg.sv
package ipv4_fwd_pkg;
  typedef struct packed {
    logic push;
    logic pop;
    logic doLpm;
    logic doArp;
  } fwdStrobes_t;

  function automatic logic [15:0] onesAdd(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[15:0] + {15'd0, s[16]};
  endfunction

  function automatic logic [15:0] hdrSum(input logic [71:0] w2, input logic [71:0] w3,
                                         input logic [71:0] w4, input logic [71:0] w5);
    logic [19:0] acc;
    logic [16:0] f;
    acc = 20'(w2[15:0]) + 20'(w3[63:48]) + 20'(w3[47:32]) + 20'(w3[31:16]) + 20'(w3[15:0])
        + 20'(w4[63:48]) + 20'(w4[47:32]) + 20'(w4[31:16]) + 20'(w4[15:0]) + 20'(w5[63:48]);
    f = 17'(acc[15:0]) + 17'(acc[19:16]);
    return f[15:0] + {15'd0, f[16]};
  endfunction
endpackage

// File: rtl/ipv4_fwd_ctrl.sv
module ipv4_fwd_ctrl
  import ipv4_fwd_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_wr,
  input  logic [7:0]               in_ctrl,
  output logic                     in_rdy,
  input  logic                     out_rdy,
  output logic                     out_wr,
  output fwdStrobes_t              strb,
  output logic [$clog2(DEPTH)-1:0] pushIdx,
  output logic [$clog2(DEPTH)-1:0] popIdx
);
  localparam int AW = $clog2(DEPTH);

  typedef enum logic [1:0] {S_RECV, S_LPM, S_ARP, S_SEND} state_t;
  state_t state;
  logic [AW-1:0] wCnt, rCnt, lastIdx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_RECV;
      wCnt    <= '0;
      rCnt    <= '0;
      lastIdx <= '0;
    end else begin
      case (state)
        S_RECV: if (in_wr) begin
          wCnt <= wCnt + 1'b1;
          if (wCnt != '0 && in_ctrl != 8'd0) begin
            lastIdx <= wCnt;
            state   <= S_LPM;
          end
        end
        S_LPM: state <= S_ARP;
        S_ARP: begin
          rCnt  <= '0;
          state <= S_SEND;
        end
        default: if (out_rdy) begin
          if (rCnt == lastIdx) begin
            wCnt  <= '0;
            state <= S_RECV;
          end else begin
            rCnt <= rCnt + 1'b1;
          end
        end
      endcase
    end
  end

  always_comb begin
    in_rdy     = (state == S_RECV);
    out_wr     = (state == S_SEND) && out_rdy;
    strb.push  = in_wr && (state == S_RECV);
    strb.pop   = out_wr;
    strb.doLpm = (state == S_LPM);
    strb.doArp = (state == S_ARP);
    pushIdx    = wCnt;
    popIdx     = rCnt;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.push && 32'(wCnt) == DEPTH - 1) |-> (in_ctrl != 8'd0)); // R12
endmodule

// File: rtl/ipv4_fwd_dpath.sv
module ipv4_fwd_dpath
  import ipv4_fwd_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int ROUTE_N   = 16,
  parameter int ARP_N     = 8,
  parameter int DEPTH     = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  fwdStrobes_t                  strb,
  input  logic [$clog2(DEPTH)-1:0]     pushIdx,
  input  logic [$clog2(DEPTH)-1:0]     popIdx,
  input  logic [63:0]                  in_data,
  input  logic [7:0]                   in_ctrl,
  input  logic                         out_wr,
  output logic [63:0]                  out_data,
  output logic [7:0]                   out_ctrl,
  input  logic                         tbl_wr,
  input  logic [1:0]                   tbl_sel,
  input  logic [$clog2(ROUTE_N)-1:0]   tbl_idx,
  input  logic                         tbl_valid,
  input  logic [31:0]                  tbl_key,
  input  logic [31:0]                  tbl_mask,
  input  logic [47:0]                  tbl_val,
  input  logic [$clog2(NUM_PORTS)-1:0] tbl_port
);
  localparam int QW = 2 * NUM_PORTS;
  localparam int SW = $clog2(QW);
  localparam int PW = $clog2(NUM_PORTS);
  localparam int TW = $clog2(ROUTE_N);
  localparam int AW = $clog2(ARP_N);

  function automatic logic [QW-1:0] cpuQueues();
    logic [QW-1:0] m;
    for (int i = 0; i < QW; i++) m[i] = (i % 2) == 1;
    return m;
  endfunction

  logic [71:0] pktMem [DEPTH];
  logic [31:0] rtPrefix [ROUTE_N];
  logic [31:0] rtMask   [ROUTE_N];
  logic [31:0] rtHop    [ROUTE_N];
  logic [PW-1:0] rtPort [ROUTE_N];
  logic        rtValid  [ROUTE_N];
  logic [31:0] arpIp    [ARP_N];
  logic [47:0] arpMac   [ARP_N];
  logic        arpValid [ARP_N];
  logic [47:0] portMac  [NUM_PORTS];

  always_ff @(posedge clk) begin
    if (strb.push) pktMem[pushIdx] <= {in_ctrl, in_data};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ROUTE_N; i++) begin
        rtValid[i] <= 1'b0; rtPrefix[i] <= '0; rtMask[i] <= '0; rtHop[i] <= '0; rtPort[i] <= '0;
      end
      for (int i = 0; i < ARP_N; i++) begin
        arpValid[i] <= 1'b0; arpIp[i] <= '0; arpMac[i] <= '0;
      end
      for (int i = 0; i < NUM_PORTS; i++) portMac[i] <= '0;
    end else if (tbl_wr) begin
      case (tbl_sel)
        2'd0: begin
          rtValid[tbl_idx]  <= tbl_valid;
          rtPrefix[tbl_idx] <= tbl_key;
          rtMask[tbl_idx]   <= tbl_mask;
          rtHop[tbl_idx]    <= tbl_val[31:0];
          rtPort[tbl_idx]   <= tbl_port;
        end
        2'd1: if (32'(tbl_idx) < ARP_N) begin
          arpValid[tbl_idx[AW-1:0]] <= tbl_valid;
          arpIp[tbl_idx[AW-1:0]]    <= tbl_key;
          arpMac[tbl_idx[AW-1:0]]   <= tbl_val;
        end
        2'd2: if (32'(tbl_idx) < NUM_PORTS) portMac[tbl_idx[PW-1:0]] <= tbl_val;
        default: ;
      endcase
    end
  end

  // Header fields, read from the stored packet
  logic [SW-1:0] srcPort;
  logic [47:0]   dstMac;
  logic [7:0]    ttl, proto;
  logic [15:0]   hc;
  logic [31:0]   dstIp;
  logic          cpuSrc, checksOk;
  always_comb begin
    srcPort  = pktMem[0][16 +: SW];
    dstMac   = pktMem[1][63:16];
    ttl      = pktMem[3][15:8];
    proto    = pktMem[3][7:0];
    hc       = pktMem[4][63:48];
    dstIp    = {pktMem[4][15:0], pktMem[5][63:48]};
    cpuSrc   = srcPort[0];
    checksOk = (dstMac == portMac[srcPort[SW-1:1]]) && (ttl > 8'd1)
            && (hdrSum(pktMem[2], pktMem[3], pktMem[4], pktMem[5]) == 16'hFFFF);
  end

  // Stage 1: longest-prefix route match, lowest index wins
  logic          lpmHit;
  logic [TW-1:0] lpmSel;
  always_comb begin
    lpmHit = 1'b0;
    lpmSel = '0;
    for (int i = ROUTE_N - 1; i >= 0; i--) begin
      if (rtValid[i] && ((dstIp ^ rtPrefix[i]) & rtMask[i]) == 32'd0) begin
        lpmHit = 1'b1;
        lpmSel = i[TW-1:0];
      end
    end
  end

  logic          hitR, okR;
  logic [31:0]   hopR;
  logic [PW-1:0] portR;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hitR <= 1'b0; okR <= 1'b0; hopR <= '0; portR <= '0;
    end else if (strb.doLpm) begin
      hitR  <= lpmHit;
      okR   <= checksOk;
      hopR  <= (rtHop[lpmSel] == 32'd0) ? dstIp : rtHop[lpmSel];
      portR <= rtPort[lpmSel];
    end
  end

  // Stage 2: next-hop MAC lookup and final queue choice
  logic          arpHit;
  logic [47:0]   arpHitMac;
  always_comb begin
    arpHit    = 1'b0;
    arpHitMac = '0;
    for (int i = ARP_N - 1; i >= 0; i--) begin
      if (arpValid[i] && arpIp[i] == hopR) begin
        arpHit    = 1'b1;
        arpHitMac = arpMac[i];
      end
    end
  end

  logic          fwdR;
  logic [QW-1:0] maskR;
  logic [47:0]   nextMacR;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fwdR <= 1'b0; maskR <= '0; nextMacR <= '0;
    end else if (strb.doArp) begin
      nextMacR <= arpHitMac;
      fwdR     <= !cpuSrc && okR && hitR && arpHit;
      if (cpuSrc)                       maskR <= QW'(1) << (srcPort - 1'b1);
      else if (okR && hitR && arpHit)   maskR <= QW'(1) << (2 * portR);
      else                              maskR <= QW'(1) << (srcPort + 1'b1);
    end
  end

  // Header rewrite on the outbound stream
  logic [47:0] outMac;
  logic [15:0] newHc;
  always_comb begin
    outMac = portMac[portR];
    newHc  = ~onesAdd(onesAdd(~hc, ~{ttl, proto}), {ttl - 8'd1, proto});
    {out_ctrl, out_data} = pktMem[popIdx];
    if (popIdx == '0) out_data[QW-1:0] = maskR;
    if (fwdR) begin
      case (32'(popIdx))
        1: out_data = {nextMacR, outMac[47:32]};
        2: out_data[63:32] = outMac[31:0];
        3: out_data[15:8] = ttl - 8'd1;
        4: out_data[63:48] = newHc;
        default: ;
      endcase
    end
  end

  AST_MASK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_wr && popIdx == '0) |-> ($countones(out_data[QW-1:0]) == 1)); // R2
  AST_FWD_TTL_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_wr && fwdR && 32'(popIdx) == 3) |-> (out_data[15:8] != 8'd0)); // R5
  AST_CPU_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_wr && popIdx == '0 && cpuSrc) |-> ((out_data[QW-1:0] & cpuQueues()) == '0)); // R10
endmodule

// File: rtl/ipv4_fwd_stage.sv
module ipv4_fwd_stage
  import ipv4_fwd_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int ROUTE_N   = 16,
  parameter int ARP_N     = 8,
  parameter int DEPTH     = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [63:0]                  in_data,
  input  logic [7:0]                   in_ctrl,
  input  logic                         in_wr,
  output logic                         in_rdy,
  output logic [63:0]                  out_data,
  output logic [7:0]                   out_ctrl,
  output logic                         out_wr,
  input  logic                         out_rdy,
  input  logic                         tbl_wr,
  input  logic [1:0]                   tbl_sel,
  input  logic [$clog2(ROUTE_N)-1:0]   tbl_idx,
  input  logic                         tbl_valid,
  input  logic [31:0]                  tbl_key,
  input  logic [31:0]                  tbl_mask,
  input  logic [47:0]                  tbl_val,
  input  logic [$clog2(NUM_PORTS)-1:0] tbl_port
);
  fwdStrobes_t strb;
  logic [$clog2(DEPTH)-1:0] pushIdx, popIdx;

  ipv4_fwd_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_wr(in_wr), .in_ctrl(in_ctrl), .in_rdy(in_rdy),
    .out_rdy(out_rdy), .out_wr(out_wr), .strb(strb), .pushIdx(pushIdx), .popIdx(popIdx)
  );

  ipv4_fwd_dpath #(.NUM_PORTS(NUM_PORTS), .ROUTE_N(ROUTE_N), .ARP_N(ARP_N), .DEPTH(DEPTH)) u_dpath (
    .clk(clk), .rst_n(rst_n), .strb(strb), .pushIdx(pushIdx), .popIdx(popIdx),
    .in_data(in_data), .in_ctrl(in_ctrl), .out_wr(out_wr),
    .out_data(out_data), .out_ctrl(out_ctrl),
    .tbl_wr(tbl_wr), .tbl_sel(tbl_sel), .tbl_idx(tbl_idx), .tbl_valid(tbl_valid),
    .tbl_key(tbl_key), .tbl_mask(tbl_mask), .tbl_val(tbl_val), .tbl_port(tbl_port)
  );

  AST_END_WORD_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_wr && popIdx != '0 && out_ctrl != 8'd0) |=> !out_wr); // R11
endmodule

// File: tb/ipv4_fwd_stage_tb.sv
module ipv4_fwd_stage_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [63:0] in_data = '0;
  logic [7:0]  in_ctrl = '0;
  logic in_wr = 1'b0, in_rdy, out_wr, out_rdy = 1'b1;
  logic [63:0] out_data;
  logic [7:0]  out_ctrl;
  logic tbl_wr = 1'b0, tbl_valid = 1'b0;
  logic [1:0]  tbl_sel = '0;
  logic [3:0]  tbl_idx = '0;
  logic [31:0] tbl_key = '0, tbl_mask = '0;
  logic [47:0] tbl_val = '0;
  logic [1:0]  tbl_port = '0;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [71:0] expQ[$];
  string tagQ[$];

  always #10 clk = ~clk;

  ipv4_fwd_stage u_dut (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_ctrl(in_ctrl), .in_wr(in_wr),
    .in_rdy(in_rdy), .out_data(out_data), .out_ctrl(out_ctrl), .out_wr(out_wr),
    .out_rdy(out_rdy), .tbl_wr(tbl_wr), .tbl_sel(tbl_sel), .tbl_idx(tbl_idx),
    .tbl_valid(tbl_valid), .tbl_key(tbl_key), .tbl_mask(tbl_mask), .tbl_val(tbl_val),
    .tbl_port(tbl_port)
  );

  function automatic logic [47:0] pmac(input int k);
    return 48'h0200_0000_0000 | 48'(k);
  endfunction

  function automatic logic [15:0] ipCsum(input logic [71:0] w2, input logic [71:0] w3,
                                         input logic [71:0] w4, input logic [71:0] w5);
    int unsigned s;
    s = w2[15:0] + w3[63:48] + w3[47:32] + w3[31:16] + w3[15:0]
      + w4[63:48] + w4[47:32] + w4[31:16] + w4[15:0] + w5[63:48];
    while (s > 32'hFFFF) s = (s & 32'hFFFF) + (s >> 16);
    return ~s[15:0];
  endfunction

  task automatic check(input bit ok, input string tag, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tblWrite(input int sel, input int idx, input bit v, input logic [31:0] key,
                          input logic [31:0] mask, input logic [47:0] val, input int port);
    @(negedge clk);
    tbl_wr = 1; tbl_sel = 2'(sel); tbl_idx = 4'(idx); tbl_valid = v;
    tbl_key = key; tbl_mask = mask; tbl_val = val; tbl_port = 2'(port);
    @(negedge clk);
    tbl_wr = 0;
  endtask

  // Driver: builds a packet, pushes the expected outbound words, then sends it
  task automatic sendPkt(input int src, input logic [47:0] dmac, input logic [31:0] dip,
                         input logic [7:0] ttl, input bit badCs, input int nPay,
                         input logic [7:0] expMask, input bit expFwd,
                         input logic [47:0] nxtMac, input logic [47:0] outSrc, input string tag);
    logic [71:0] w[10];
    logic [71:0] e;
    int n;
    logic [47:0] smac;
    smac = 48'h0A0B_0C0D_0E0F;
    n = 6 + nPay;
    w[0] = {8'hff, 16'(n * 8), 29'd0, 3'(src), 16'd0};
    w[1] = {8'h00, dmac, smac[47:32]};
    w[2] = {8'h00, smac[31:0], 16'h0800, 16'h4500};
    w[3] = {8'h00, 16'(n * 8 - 14), 16'h1234, 16'h4000, ttl, 8'h06};
    w[4] = {8'h00, 16'h0000, 32'hC0A8_0101, dip[31:16]};
    w[5] = {8'h00, dip[15:0], 48'h5A5A_0000_0000 | 48'(src)};
    for (int i = 0; i < nPay; i++) w[6 + i] = {8'h00, 64'hC0DE_0000_0000_0000 | 64'(i)};
    w[n - 1][71:64] = 8'h10;
    w[4][63:48] = ipCsum(w[2], w[3], w[4], w[5]) ^ (badCs ? 16'h0001 : 16'h0000);
    for (int i = 0; i < n; i++) begin
      e = w[i];
      if (i == 0) e[7:0] = expMask;
      if (expFwd) begin
        if (i == 1) e[63:0] = {nxtMac, outSrc[47:32]};
        if (i == 2) e[63:32] = outSrc[31:0];
        if (i == 3) e[15:8] = ttl - 8'd1;
      end
      if (expFwd && i == 4) begin
        logic [71:0] m2, m3, m4;
        m2 = e; m3 = w[3]; m3[15:8] = ttl - 8'd1; m4 = w[4]; m4[63:48] = 16'h0;
        m2 = w[2];
        e[63:48] = ipCsum(m2, m3, m4, w[5]);
      end
      expQ.push_back(e);
      tagQ.push_back($sformatf("%s word %0d", tag, i));
    end
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!in_rdy) begin in_wr = 0; @(negedge clk); end
      {in_ctrl, in_data} = w[i];
      in_wr = 1;
    end
    @(negedge clk);
    in_wr = 0;
  endtask

  // Backpressure pattern
  initial begin
    logic [7:0] lfsr;
    lfsr = 8'hA5;
    forever begin
      @(negedge clk);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_rdy = lfsr[0] | lfsr[2];
    end
  end

  // Monitor / scoreboard
  initial begin
    logic [71:0] e;
    forever begin
      @(negedge clk); #5;
      if (rst_n && out_wr) begin
        if (expQ.size() == 0) begin
          check(0, "R11 unexpected word", {out_ctrl, out_data}, 72'd0);
        end else begin
          e = expQ.pop_front();
          check({out_ctrl, out_data} === e, tagQ.pop_front(), {out_ctrl, out_data}, e);
        end
        check(in_rdy == 1'b0, "R12 in_rdy low while draining", 72'(in_rdy), 72'd0);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #5;
    check(in_rdy == 1'b1 && out_wr == 1'b0, "R1 reset state", {70'd0, in_rdy, out_wr}, 72'd2);

    for (int k = 0; k < 4; k++) tblWrite(2, k, 1, 0, 0, pmac(k), 0);
    tblWrite(0, 0, 1, 32'h0A01_0200, 32'hFFFF_FF00, 48'h0A09_0002, 1);
    tblWrite(0, 1, 1, 32'h0A01_0000, 32'hFFFF_0000, 48'h0A09_0003, 2);
    tblWrite(0, 2, 1, 32'h0A02_0000, 32'hFFFF_0000, 48'h0,        3);
    tblWrite(1, 0, 1, 32'h0A09_0002, 0, 48'hAAAA_0000_0001, 0);
    tblWrite(1, 1, 1, 32'h0A09_0003, 0, 48'hBBBB_0000_0002, 0);
    tblWrite(1, 2, 1, 32'h0A02_0007, 0, 48'hCCCC_0000_0003, 0);

    sendPkt(0, pmac(0), 32'h0A01_0205, 8'd64, 0, 2, 8'h04, 1, 48'hAAAA_0000_0001, pmac(1), "R3 R4 R8 fwd /24");
    sendPkt(4, pmac(2), 32'h0A01_0701, 8'd30, 0, 1, 8'h10, 1, 48'hBBBB_0000_0002, pmac(2), "R2 R8 fwd /16");
    sendPkt(2, pmac(1), 32'h0A02_0007, 8'd9,  0, 3, 8'h40, 1, 48'hCCCC_0000_0003, pmac(3), "R9 direct hop");
    sendPkt(2, pmac(1), 32'h0A02_0008, 8'd9,  0, 0, 8'h08, 0, 0, 0, "R9 ARP miss");
    sendPkt(0, pmac(0), 32'h0A03_0001, 8'd9,  0, 1, 8'h02, 0, 0, 0, "R8 no route");
    sendPkt(0, pmac(0), 32'h0A01_0205, 8'd1,  0, 1, 8'h02, 0, 0, 0, "R5 TTL 1");
    sendPkt(6, pmac(3), 32'h0A01_0205, 8'd0,  0, 2, 8'h80, 0, 0, 0, "R5 TTL 0");
    sendPkt(4, pmac(2), 32'h0A01_0205, 8'd64, 1, 1, 8'h20, 0, 0, 0, "R6 bad checksum");
    sendPkt(0, pmac(1), 32'h0A01_0205, 8'd64, 0, 1, 8'h02, 0, 0, 0, "R7 MAC mismatch");
    sendPkt(3, pmac(3), 32'h0A03_0001, 8'd0,  1, 2, 8'h04, 0, 0, 0, "R10 CPU bypass");
    sendPkt(0, pmac(0), 32'h0A01_0205, 8'd2,  0, 0, 8'h04, 1, 48'hAAAA_0000_0001, pmac(1), "R4 TTL 2 edge");
    sendPkt(6, pmac(3), 32'h0A01_0999, 8'd5,  0, 3, 8'h10, 1, 48'hBBBB_0000_0002, pmac(2), "R11 backpressure");

    for (int t = 0; t < 2000 && expQ.size() != 0; t++) @(negedge clk);
    repeat (20) @(negedge clk);
    check(expQ.size() == 0, "R11 all words delivered", 72'(expQ.size()), 72'd0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule